// File: doc/BRIEF.md
# Host Port Memory Window Bridge

This block is the slave side of a host port. An external processor drives a non-multiplexed bus with a 20-bit address and 16-bit data, and it appears to see one large memory window. Behind the window there are only two 16-bit registers. One is a data holding register. The other is a control register. A small internal transfer engine moves words between the holding register and an on-chip RAM at the address the host presented.

Before touching the RAM, the engine waits a set number of cycles, which models arbitration for the internal memory. A ready output tells the host when its access may finish. Writes to the data register complete at once and are committed later in the background. Reads stall the host until the word has been fetched. A write that arrives while an earlier transfer is still pending also stalls.

While the block is deselected, ready reads high. For a short window after select rises, ready also shows a stale high level. Bus control signals are sampled on the clock, and each access begins on the rising edge of the strobe.

Top module: `hpw_bridge`

## Requirements
- R1: After reset, both registers hold zero, `hready` is high and no transfer is pending.
- R2: While `hsel` is low, `hready` is high, whatever the other inputs do.
- R3: Counting the first cycle in which `hsel` is seen high, `hready` stays high for `STALE_CYCLES` cycles (default 3), whatever the access state.
- R4: When `hreg_sel` is 0, an access goes to the control register. A write stores `hwdata`, a read returns the stored value on `hrdata`, `hready` does not drop, and the RAM is untouched.
- R5: When `hreg_sel` is 1 and `hwrite` is 1 with the engine idle, the write completes with no stall. The word is stored at RAM index `haddr[RAM_AW-1:0]`.
- R6: When `hreg_sel` is 1 and `hwrite` is 0 with the engine idle, `hready` is low for exactly `ARB_CYCLES`+1 cycles, starting the cycle after the strobe edge is sampled. After that, `hrdata` shows the fetched word.
- R7: Suppose a data write starts while an earlier transfer is in flight. `hready` then stays low until that transfer finishes and the new one is launched. With a gap of g cycles between the two strobe edges, it is low for `ARB_CYCLES`+2-g cycles, and both words reach the RAM.
- R8: An access starts only on a sampled rising edge of `hstrobe` while `hsel` is high. A strobe held high starts nothing further, and a strobe edge while `hsel` is low is ignored.
- R9: Address bits at and above `RAM_AW` are ignored, so addresses that differ only there reach the same word.
- R10: A read returns the most recent write to the same word, even when the read is issued while that write is still being committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsel | input | 1 | Host chip select, active high |
| hstrobe | input | 1 | Data strobe; its rising edge starts an access |
| hwrite | input | 1 | 1 = write, 0 = read |
| hreg_sel | input | 1 | 1 = data register (memory window), 0 = control register |
| haddr | input | ADDR_W (20) | Host word address |
| hwdata | input | DATA_W (16) | Host write data |
| hrdata | output | DATA_W (16) | Selected register contents |
| hready | output | 1 | Access may complete |

## Verification
Inputs change on the falling clock edge, and outputs are read just after the next falling edge, half a cycle after the rising edge that acted on them.

A data write reports ready in the first cycle after its strobe edge. A data read stays low for `ARB_CYCLES`+1 sampled cycles. A queued write stays low for `ARB_CYCLES`+2 minus its gap from the earlier strobe edge.

In the select-and-read test, the stale window and the real stall overlap. There, ready is checked cycle by cycle against a table the bench derives from both parameters. Control-register accesses are checked for a ready level that never drops.

// File: rtl/hpw_pkg.sv
package hpw_pkg;

  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_ARB  = 2'd1,
    ENG_XFER = 2'd2
  } eng_state_t;

  // True when a counter that started at zero has spent `limit` cycles.
  function automatic logic count_hit(int unsigned cnt, int unsigned limit);
    return (cnt + 1) >= limit;
  endfunction

  // Cycles that a read on an idle engine keeps ready low.
  function automatic int unsigned read_stall(int unsigned arb_cycles);
    return arb_cycles + 1;
  endfunction

endpackage

// File: rtl/hpw_host_decode.sv
module hpw_host_decode #(
  parameter int STALE_CYCLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hsel,
  input  logic hstrobe,
  output logic start_o,
  output logic stale_o
);
  localparam int   LOADV     = (STALE_CYCLES > 0) ? STALE_CYCLES - 1 : 0;
  localparam int   CW        = $clog2(LOADV + 2);
  localparam logic HAS_STALE = (STALE_CYCLES > 0);

  logic          sel_q;
  logic          strb_q;
  logic [CW-1:0] mask_cnt;
  logic          sel_rise;

  assign sel_rise = hsel & ~sel_q;
  assign start_o  = hsel & hstrobe & ~strb_q;
  assign stale_o  = HAS_STALE & (sel_rise | (mask_cnt != '0));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q    <= 1'b0;
      strb_q   <= 1'b0;
      mask_cnt <= '0;
    end else begin
      sel_q  <= hsel;
      strb_q <= hstrobe;
      if (!hsel)                 mask_cnt <= '0;
      else if (sel_rise)         mask_cnt <= CW'(LOADV);
      else if (mask_cnt != '0)   mask_cnt <= mask_cnt - 1'b1;
    end
  end
endmodule

// File: rtl/hpw_xfer_engine.sv
module hpw_xfer_engine
  import hpw_pkg::*;
#(
  parameter int ARB_CYCLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch_i,
  output logic idle_o,
  output logic xfer_o
);
  localparam int AC = (ARB_CYCLES < 1) ? 1 : ARB_CYCLES;
  localparam int CW = $clog2(AC + 1);

  eng_state_t    state;
  logic [CW-1:0] cnt;

  assign idle_o = (state == ENG_IDLE);
  assign xfer_o = (state == ENG_XFER);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ENG_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        ENG_IDLE: if (launch_i) begin
          state <= ENG_ARB;
          cnt   <= '0;
        end
        ENG_ARB: begin
          if (count_hit(int'(cnt), AC)) state <= ENG_XFER;
          else                          cnt   <= cnt + 1'b1;
        end
        ENG_XFER: state <= ENG_IDLE;
        default:  state <= ENG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hpw_ram.sv
module hpw_ram #(
  parameter int AW = 10,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/hpw_bridge.sv
module hpw_bridge #(
  parameter int ADDR_W       = 20,
  parameter int DATA_W       = 16,
  parameter int RAM_AW       = 10,
  parameter int ARB_CYCLES   = 3,
  parameter int STALE_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsel,
  input  logic              hstrobe,
  input  logic              hwrite,
  input  logic              hreg_sel,
  input  logic [ADDR_W-1:0] haddr,
  input  logic [DATA_W-1:0] hwdata,
  output logic [DATA_W-1:0] hrdata,
  output logic              hready
);
  // named internal events, also observed by the bound checker
  logic start, stale, launch, eng_idle, eng_xfer;
  logic pend_valid, rd_wait;

  logic              new_req, launch_now, launch_pend, defer;
  logic              l_read;
  logic [RAM_AW-1:0] l_addr;
  logic [DATA_W-1:0] l_data;

  logic [DATA_W-1:0] data_q, ctrl_q, pend_data, ram_rdata;
  logic [RAM_AW-1:0] xaddr_q, pend_addr;
  logic              xread_q, pend_read;
  logic              unused_addr_bits;

  assign unused_addr_bits = ^haddr[ADDR_W-1:RAM_AW];

  hpw_host_decode #(.STALE_CYCLES(STALE_CYCLES)) u_dec (
    .clk(clk), .rst_n(rst_n), .hsel(hsel), .hstrobe(hstrobe),
    .start_o(start), .stale_o(stale)
  );

  hpw_xfer_engine #(.ARB_CYCLES(ARB_CYCLES)) u_eng (
    .clk(clk), .rst_n(rst_n), .launch_i(launch),
    .idle_o(eng_idle), .xfer_o(eng_xfer)
  );

  hpw_ram #(.AW(RAM_AW), .DW(DATA_W)) u_ram (
    .clk(clk), .we(eng_xfer & ~xread_q), .addr(xaddr_q),
    .wdata(data_q), .rdata(ram_rdata)
  );

  assign new_req     = start & hreg_sel;
  assign launch_now  = new_req & eng_idle & ~pend_valid;
  assign launch_pend = pend_valid & eng_idle;
  assign defer       = new_req & ~launch_now;
  assign launch      = launch_now | launch_pend;

  assign l_read = launch_pend ? pend_read : ~hwrite;
  assign l_addr = launch_pend ? pend_addr : haddr[RAM_AW-1:0];
  assign l_data = launch_pend ? pend_data : hwdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q     <= '0;
      ctrl_q     <= '0;
      xaddr_q    <= '0;
      xread_q    <= 1'b0;
      pend_valid <= 1'b0;
      pend_read  <= 1'b0;
      pend_addr  <= '0;
      pend_data  <= '0;
      rd_wait    <= 1'b0;
    end else begin
      if (start && !hreg_sel && hwrite) ctrl_q <= hwdata;

      if (defer) begin
        pend_valid <= 1'b1;
        pend_read  <= ~hwrite;
        pend_addr  <= haddr[RAM_AW-1:0];
        pend_data  <= hwdata;
      end else if (launch_pend) begin
        pend_valid <= 1'b0;
      end

      if (launch) begin
        xaddr_q <= l_addr;
        xread_q <= l_read;
        if (l_read) rd_wait <= 1'b1;
        else        data_q  <= l_data;
      end

      if (eng_xfer && xread_q) begin
        data_q  <= ram_rdata;
        rd_wait <= 1'b0;
      end
    end
  end

  assign hready = ~hsel | stale | (~pend_valid & ~rd_wait);
  assign hrdata = hreg_sel ? data_q : ctrl_q;
endmodule

// File: rtl/hpw_bridge_chk.sv
module hpw_bridge_chk (
  input logic clk,
  input logic rst_n,
  input logic hsel,
  input logic hreg_sel,
  input logic hready,
  input logic start,
  input logic stale,
  input logic launch,
  input logic pend_valid,
  input logic rd_wait,
  input logic eng_idle
);
  assert_desel_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !hsel |-> hready);

  assert_stale_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hsel && !$past(hsel)) |-> hready);

  assert_ctrl_no_launch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !hreg_sel && !pend_valid) |-> !launch);

  assert_launch_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> !eng_idle);

  assert_read_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hsel && !stale && rd_wait) |-> !hready);

  assert_pend_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hsel && !stale && pend_valid) |-> !hready);

  assert_single_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !start);
endmodule

bind hpw_bridge hpw_bridge_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hsel(hsel), .hreg_sel(hreg_sel),
  .hready(hready), .start(start), .stale(stale), .launch(launch),
  .pend_valid(pend_valid), .rd_wait(rd_wait), .eng_idle(eng_idle)
);

// File: tb/test_hpw_bridge.sv
module test_hpw_bridge;
  localparam int ADDR_W = 20;
  localparam int DATA_W = 16;
  localparam int RAM_AW = 10;
  localparam int ARB    = 3;
  localparam int STALE  = 3;

  logic              clk = 1'b0;
  logic              rst_n, hsel, hstrobe, hwrite, hreg_sel;
  logic [ADDR_W-1:0] haddr;
  logic [DATA_W-1:0] hwdata;
  logic [DATA_W-1:0] hrdata;
  logic              hready;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  hpw_bridge #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RAM_AW(RAM_AW),
               .ARB_CYCLES(ARB), .STALE_CYCLES(STALE)) i_hpw_bridge (
    .clk(clk), .rst_n(rst_n), .hsel(hsel), .hstrobe(hstrobe),
    .hwrite(hwrite), .hreg_sel(hreg_sel), .haddr(haddr),
    .hwdata(hwdata), .hrdata(hrdata), .hready(hready)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  // one host access; returns the number of sampled cycles ready was low
  task automatic host_op(input logic is_data, input logic wr,
                         input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                         output int low);
    low = 0;
    @(negedge clk);
    hreg_sel = is_data; hwrite = wr; haddr = a; hwdata = d; hstrobe = 1'b1;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk); #1;
      if (hready) break;
      low++;
    end
    hstrobe = 1'b0;
  endtask

  task automatic idle_wait(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    #1;
    hreg_sel = 1'b0; #1;
    chk("R1 ctrl reg after reset", hrdata, 0);
    hreg_sel = 1'b1; #1;
    chk("R1 data reg after reset", hrdata, 0);
    chk("R1 ready after reset", hready, 1);
  endtask

  task automatic t_deselect_R2();
    hsel = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); hstrobe = ~hstrobe; hwrite = 1'b0; hreg_sel = 1'b1; #1;
      chk("R2 ready while deselected", hready, 1);
    end
    @(negedge clk); hstrobe = 1'b0;
  endtask

  task automatic select_settle();
    @(negedge clk); hsel = 1'b1;
    idle_wait(STALE + 2);
  endtask

  task automatic t_stale_read_R3_R6();
    int lo;
    host_op(1, 1, 20'h00123, 16'hC0DE, lo);
    idle_wait(ARB + 3);
    @(negedge clk); hsel = 1'b0;
    idle_wait(2);
    hreg_sel = 1'b1; hwrite = 1'b0; haddr = 20'h00123; hsel = 1'b1; hstrobe = 1'b1; #1;
    chk("R3 ready in first selected cycle", hready, 1);
    for (int k = 0; k <= ARB + 1; k++) begin
      @(negedge clk); #1;
      chk($sformatf("R3/R6 ready %0d cycles after strobe edge", k), hready,
          ((k < STALE - 1) || (k >= ARB + 1)) ? 1 : 0);
    end
    chk("R6 fetched word", hrdata, 16'hC0DE);
    hstrobe = 1'b0;
  endtask

  task automatic t_ctrl_R4();
    int lo;
    host_op(1, 1, 20'h00200, 16'h1111, lo);
    idle_wait(ARB + 3);
    host_op(0, 1, 20'h00200, 16'hBEEF, lo);
    chk("R4 ctrl write stall", lo, 0);
    host_op(0, 0, 20'h00200, 16'h0000, lo);
    chk("R4 ctrl read stall", lo, 0);
    chk("R4 ctrl read value", hrdata, 16'hBEEF);
    host_op(1, 0, 20'h00200, 16'h0000, lo);
    chk("R4 RAM untouched by ctrl write", hrdata, 16'h1111);
  endtask

  task automatic t_write_read_R5_R6();
    int lo;
    idle_wait(ARB + 3);
    host_op(1, 1, 20'h002A5, 16'h5A5A, lo);
    chk("R5 idle write stall", lo, 0);
    idle_wait(ARB + 3);
    host_op(1, 0, 20'h002A5, 16'h0000, lo);
    chk("R6 read stall length", lo, ARB + 1);
    chk("R5 word stored at index", hrdata, 16'h5A5A);
  endtask

  task automatic t_queued_write_R7_R10();
    int lo;
    idle_wait(ARB + 3);
    host_op(1, 1, 20'h00031, 16'hAAAA, lo);
    chk("R7 first write no stall", lo, 0);
    host_op(1, 1, 20'h00032, 16'hBBBB, lo);
    chk("R7 queued write stall (gap 2)", lo, ARB + 2 - 2);
    host_op(1, 1, 20'h00031, 16'hCCCC, lo);
    host_op(1, 0, 20'h00031, 16'h0000, lo);
    chk("R10 read after in-flight write", hrdata, 16'hCCCC);
    host_op(1, 0, 20'h00032, 16'h0000, lo);
    chk("R7 second word landed", hrdata, 16'hBBBB);
  endtask

  task automatic t_alias_R9();
    int lo;
    host_op(1, 1, 20'h00015, 16'h7E7E, lo);
    host_op(1, 0, 20'h80415, 16'h0000, lo);
    chk("R9 high address bits ignored", hrdata, 16'h7E7E);
  endtask

  task automatic t_edge_R8();
    int lo;
    idle_wait(ARB + 3);
    @(negedge clk);
    hreg_sel = 1'b1; hwrite = 1'b0; haddr = 20'h002A5; hstrobe = 1'b1;
    for (int i = 0; i < ARB + 3; i++) @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); #1;
      chk("R8 held strobe starts nothing", hready, 1);
    end
    hstrobe = 1'b0;
    @(negedge clk); hsel = 1'b0; hwrite = 1'b1; hwdata = 16'hDEAD;
    @(negedge clk); hstrobe = 1'b1;
    @(negedge clk); hstrobe = 1'b0;
    @(negedge clk); hsel = 1'b1;
    idle_wait(STALE + ARB + 3);
    host_op(1, 0, 20'h002A5, 16'h0000, lo);
    chk("R8 deselected strobe ignored", hrdata, 16'h5A5A);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; hsel = 1'b0; hstrobe = 1'b0; hwrite = 1'b0;
    hreg_sel = 1'b0; haddr = '0; hwdata = '0;
    idle_wait(3);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_deselect_R2();
    select_settle();
    t_stale_read_R3_R6();
    t_ctrl_R4();
    t_write_read_R5_R6();
    t_queued_write_R7_R10();
    t_alias_R9();
    t_edge_R8();
    finished = 1'b1;
    summary();
    $finish;
  end
endmodule